// File: doc/BRIEF.md
# Clock-Line Command Decoder with Bunch Timestamp Check

This block sits at the receiving end of a distributed clock wire that also carries commands. It oversamples the wire four times per clock period. A period that shows the plain clock shape counts as an idle bunch. Two distorted shapes act as markers. The first marker restarts the bunch timestamp and the event number. The second marker is either a trigger or a periodic timestamp check, depending on the timestamp at which it arrives.

On a trigger, the block captures the current timestamp and event number into a header and pulses a valid strobe for one clock. The timestamp counts modulo 294. The sender places a check marker on the last bunch of every turn. A missing check marker, or any period shape the block does not recognise, raises a sticky error flag. Only a restart marker clears these flags. The header carries the event number, so event-count slips can also be found later, by comparing headers across channels.

Top module: `ccd_top`

## Requirements
- R1: The line is sampled once per clock. After reset is released, every four consecutive samples form one period, and the first sample is the most significant bit of the 4-bit pattern. The pattern 1100 is an idle period and raises no error.
- R2: Pattern 1000 is a restart marker. It sets timestamp and event number to 0 and clears both error flags, so the period that follows has timestamp 0.
- R3: The timestamp advances by one per period and wraps from 293 to 0. Every non-restart period advances it, including one with an unknown pattern.
- R4: Pattern 1110 at a timestamp other than 293 is a trigger. hdr_ts and hdr_ev take that period's timestamp and the event number before the trigger. hdr_valid is high for exactly one clock, and it rises on the clock edge after the edge that takes the period's fourth sample.
- R5: The 16-bit event number increases by one after every trigger, so back-to-back triggers report consecutive numbers.
- R6: Pattern 1110 at timestamp 293 is a check marker. It produces no header and leaves the event number unchanged.
- R7: ts_err is set when the period at timestamp 293 is not pattern 1110. It stays set through later periods and correct check markers until a restart marker arrives.
- R8: Any pattern other than 1100, 1000 or 1110 sets frame_err, which stays set until a restart marker.
- R9: While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four cycles per line period |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled clock-line level |
| hdr_ts | output | 9 | Timestamp captured at the last trigger |
| hdr_ev | output | 16 | Event number captured at the last trigger |
| hdr_valid | output | 1 | One-clock strobe for a new header |
| ts_err | output | 1 | Sticky missing-check-marker flag |
| frame_err | output | 1 | Sticky unknown-pattern flag |

## Verification
A period's pattern is registered on the edge that takes its fourth sample. Counters, flags and the header are updated one edge later. As a result, the header strobe appears during the first sample of the next period. The monitor samples hdr_valid at every falling edge and pops an expected header from the queue whenever the strobe is seen. Flag checks are made only after one more full period has been sent, so the flags then reflect the period before last, and the bench compares them against a model value lagged by one period.

// File: rtl/ccd_pkg.sv
// Shared definitions for the clock-line command decoder.
// Assumes four line samples per period, first sample in the MSB.
package ccd_pkg;
    localparam int OVS = 4;
    localparam logic [OVS-1:0] PAT_IDLE    = 4'b1100;
    localparam logic [OVS-1:0] PAT_RESTART = 4'b1000;
    localparam logic [OVS-1:0] PAT_MARK    = 4'b1110;

    typedef enum logic [1:0] {
        SYM_IDLE    = 2'd0,
        SYM_RESTART = 2'd1,
        SYM_MARK    = 2'd2,
        SYM_BAD     = 2'd3
    } sym_t;

    // Map one period's sample pattern onto a symbol kind.
    function automatic sym_t classify(input logic [OVS-1:0] pat);
        case (pat)
            PAT_IDLE:    return SYM_IDLE;
            PAT_RESTART: return SYM_RESTART;
            PAT_MARK:    return SYM_MARK;
            default:     return SYM_BAD;
        endcase
    endfunction
endpackage

// File: rtl/ccd_slicer.sv
// Cuts the oversampled line into periods and classifies each one.
// Assumes the period boundary lines up with reset release: the first
// sample after reset is the first sample of a period. It also keeps
// the sticky unknown-pattern flag, which only this stage can detect.
module ccd_slicer
    import ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic sym_stb,
    output sym_t sym_kind,
    output logic frame_err
);
    localparam int PH_W = $clog2(OVS);

    logic [PH_W-1:0] phase;
    logic [OVS-2:0]  hist;
    logic            last_ph;

    assign last_ph = (phase == PH_W'(OVS - 1));

    // Sample position inside the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= last_ph ? '0 : phase + 1'b1;
    end

    // Keep the earlier samples of the period, oldest on top.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[OVS-3:0], line_in};
    end

    // Register the classified symbol on the edge that takes the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_stb  <= 1'b0;
            sym_kind <= SYM_IDLE;
        end else begin
            sym_stb  <= last_ph;
            if (last_ph) sym_kind <= classify({hist, line_in});
        end
    end

    // Sticky flag for unknown patterns; a restart clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_err <= 1'b0;
        else if (sym_stb) begin
            if (sym_kind == SYM_RESTART)  frame_err <= 1'b0;
            else if (sym_kind == SYM_BAD) frame_err <= 1'b1;
        end
    end
endmodule

// File: rtl/ccd_bunch.sv
// Bunch timestamp counter with a non-power-of-two modulus and a check
// on the periodic marker. Assumes one strobe per period from the slicer.
module ccd_bunch
    import ccd_pkg::*;
#(
    parameter  int TS_MOD = 294,
    localparam int TS_W   = $clog2(TS_MOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sym_stb,
    input  sym_t            sym_kind,
    output logic [TS_W-1:0] ts,
    output logic            at_wrap,
    output logic            ts_err
);
    assign at_wrap = (ts == TS_W'(TS_MOD - 1));

    // Advance once per period and wrap at the modulus; restart zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else if (sym_stb) begin
            if (sym_kind == SYM_RESTART) ts <= '0;
            else                         ts <= at_wrap ? '0 : ts + 1'b1;
        end
    end

    // Sticky flag set when the last bunch of a turn lacks its marker.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_err <= 1'b0;
        else if (sym_stb) begin
            if (sym_kind == SYM_RESTART)                ts_err <= 1'b0;
            else if (at_wrap && sym_kind != SYM_MARK)   ts_err <= 1'b1;
        end
    end
endmodule

// File: rtl/ccd_header.sv
// Event counter and trigger header capture. A marker on the last bunch
// is a check, not a trigger. Assumes the timestamp and the wrap flag
// describe the period that is being strobed.
module ccd_header
    import ccd_pkg::*;
#(
    parameter int TS_W = 9,
    parameter int EV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sym_stb,
    input  sym_t            sym_kind,
    input  logic [TS_W-1:0] ts,
    input  logic            at_wrap,
    output logic [EV_W-1:0] ev,
    output logic [TS_W-1:0] hdr_ts,
    output logic [EV_W-1:0] hdr_ev,
    output logic            hdr_valid
);
    logic trig;

    assign trig = sym_stb && (sym_kind == SYM_MARK) && !at_wrap;

    // Count triggers; restart zeroes the count.
    always_ff @(posedge clk) begin
        if (!rst_n) ev <= '0;
        else if (sym_stb && sym_kind == SYM_RESTART) ev <= '0;
        else if (trig)                               ev <= ev + 1'b1;
    end

    // Capture the header fields and pulse the strobe on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ts    <= '0;
            hdr_ev    <= '0;
            hdr_valid <= 1'b0;
        end else begin
            hdr_valid <= trig;
            if (trig) begin
                hdr_ts <= ts;
                hdr_ev <= ev;
            end
        end
    end
endmodule

// File: rtl/ccd_top.sv
// Clock-line command decoder top: slicer -> timestamp -> header.
// Assumes line_in is already synchronous to clk at four samples a period.
module ccd_top
    import ccd_pkg::*;
#(
    parameter  int TS_MOD = 294,
    parameter  int EV_W   = 16,
    localparam int TS_W   = $clog2(TS_MOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_in,
    output logic [TS_W-1:0] hdr_ts,
    output logic [EV_W-1:0] hdr_ev,
    output logic            hdr_valid,
    output logic            ts_err,
    output logic            frame_err
);
    logic            sym_stb;
    sym_t            sym_kind;
    logic [TS_W-1:0] ts;
    logic            at_wrap;
    logic [EV_W-1:0] ev;

    ccd_slicer u_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .sym_stb   (sym_stb),
        .sym_kind  (sym_kind),
        .frame_err (frame_err)
    );

    ccd_bunch #(.TS_MOD(TS_MOD)) u_bunch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_stb  (sym_stb),
        .sym_kind (sym_kind),
        .ts       (ts),
        .at_wrap  (at_wrap),
        .ts_err   (ts_err)
    );

    ccd_header #(.TS_W(TS_W), .EV_W(EV_W)) u_header (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_stb   (sym_stb),
        .sym_kind  (sym_kind),
        .ts        (ts),
        .at_wrap   (at_wrap),
        .ev        (ev),
        .hdr_ts    (hdr_ts),
        .hdr_ev    (hdr_ev),
        .hdr_valid (hdr_valid)
    );
endmodule

// File: rtl/ccd_chk.sv
// Property checker for ccd_top, attached with bind.
module ccd_chk
    import ccd_pkg::*;
#(
    parameter int TS_MOD = 294,
    parameter int TS_W   = 9,
    parameter int EV_W   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sym_stb,
    input sym_t            sym_kind,
    input logic [TS_W-1:0] ts,
    input logic [EV_W-1:0] ev,
    input logic [TS_W-1:0] hdr_ts,
    input logic            hdr_valid,
    input logic            ts_err,
    input logic            frame_err
);
    // R1: one symbol strobe per period, never two in a row
    a_r1_stb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> !sym_stb);

    // R2: restart zeroes counters and flags
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && sym_kind == SYM_RESTART) |=>
            (ts == '0 && ev == '0 && !ts_err && !frame_err));

    // R3: timestamp stays inside the modulus
    a_r3_ts_range: assert property (@(posedge clk) disable iff (!rst_n)
        ts <= TS_W'(TS_MOD - 1));

    // R4: strobe lasts one clock and never reports the check bunch
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> !hdr_valid);
    a_r4_hdr_not_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> hdr_ts != TS_W'(TS_MOD - 1));

    // R5: a trigger steps the event number by one
    a_r5_ev_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && sym_kind == SYM_MARK && ts != TS_W'(TS_MOD - 1)) |=>
            ev == EV_W'($past(ev) + 1'b1));

    // R6: check marker makes no header and keeps the event number
    a_r6_check_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && sym_kind == SYM_MARK && ts == TS_W'(TS_MOD - 1)) |=>
            (!hdr_valid && $stable(ev)));

    // R7: timestamp error holds until restart
    a_r7_ts_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_err && !(sym_stb && sym_kind == SYM_RESTART)) |=> ts_err);

    // R8: framing error holds until restart
    a_r8_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !(sym_stb && sym_kind == SYM_RESTART)) |=> frame_err);
endmodule

bind ccd_top ccd_chk #(.TS_MOD(TS_MOD), .TS_W(TS_W), .EV_W(EV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .sym_kind  (sym_kind),
    .ts        (ts),
    .ev        (ev),
    .hdr_ts    (hdr_ts),
    .hdr_valid (hdr_valid),
    .ts_err    (ts_err),
    .frame_err (frame_err)
);

// File: tb/ccd_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each period and queues headers,
// the monitor pops them when the strobe appears.
module ccd_top_tb;
    localparam int TS_MOD = 294;
    localparam int K_IDLE = 0, K_RESTART = 1, K_MARK = 2, K_BAD = 3;

    typedef struct { int ts; int ev; } hdr_exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic [8:0]  hdr_ts;
    logic [15:0] hdr_ev;
    logic        hdr_valid, ts_err, frame_err;

    hdr_exp_t q[$];
    int n_chk = 0, n_fail = 0, n_hdr = 0, n_exp_hdr = 0;
    int m_ts = 0, m_ev = 0;
    bit m_ts_err = 0, m_fr_err = 0, lag_ts_err = 0, lag_fr_err = 0;

    always #2 clk = ~clk;

    ccd_top u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .hdr_ts(hdr_ts), .hdr_ev(hdr_ev), .hdr_valid(hdr_valid),
        .ts_err(ts_err), .frame_err(frame_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pat_of(input int k);
        case (k)
            K_RESTART: return 4'b1000;
            K_MARK:    return 4'b1110;
            K_BAD:     return 4'b0110;
            default:   return 4'b1100;
        endcase
    endfunction

    // Update the model for one period, then drive its four samples.
    task automatic send_sym(input int k);
        logic [3:0] p;
        hdr_exp_t e;
        lag_ts_err = m_ts_err;
        lag_fr_err = m_fr_err;
        if (k == K_RESTART) begin
            m_ts = 0; m_ev = 0; m_ts_err = 0; m_fr_err = 0;
        end else begin
            if (m_ts == TS_MOD - 1 && k != K_MARK) m_ts_err = 1;
            if (k == K_BAD) m_fr_err = 1;
            if (k == K_MARK && m_ts != TS_MOD - 1) begin
                e.ts = m_ts; e.ev = m_ev;
                q.push_back(e);
                n_exp_hdr++;
                m_ev++;
            end
            m_ts = (m_ts == TS_MOD - 1) ? 0 : m_ts + 1;
        end
        p = pat_of(k);
        for (int i = 3; i >= 0; i--) begin
            line_in = p[i];
            @(negedge clk);
        end
    endtask

    task automatic run_to(input int t);
        while (m_ts != t) send_sym(K_IDLE);
    endtask

    // Flags now reflect the period before the last one sent.
    task automatic check_flags(input string tag);
        check({tag, " ts_err"}, int'(ts_err), int'(lag_ts_err));
        check({tag, " frame_err"}, int'(frame_err), int'(lag_fr_err));
    endtask

    // Monitor: compare every header strobe with the queue head.
    always @(negedge clk) begin
        if (hdr_valid === 1'b1) begin
            n_hdr++;
            if (q.size() == 0) begin
                check("R6 unexpected header ts", int'(hdr_ts), -1);
            end else begin
                hdr_exp_t e;
                e = q.pop_front();
                check("R4 header timestamp", int'(hdr_ts), e.ts);
                check("R5 header event number", int'(hdr_ev), e.ev);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset hdr_valid", int'(hdr_valid), 0);
        check("R9 reset hdr_ts", int'(hdr_ts), 0);
        check("R9 reset hdr_ev", int'(hdr_ev), 0);
        check("R9 reset ts_err", int'(ts_err), 0);
        check("R9 reset frame_err", int'(frame_err), 0);
        rst_n = 1'b1;

        send_sym(K_RESTART);
        run_to(10);
        check_flags("R1 idle periods");
        send_sym(K_MARK);               // R4: header (10,0)
        send_sym(K_MARK);               // R5: header (11,1)
        run_to(TS_MOD - 1);
        send_sym(K_MARK);               // R6: check marker, no header
        send_sym(K_MARK);               // R3: wrapped, header (0,2)
        check_flags("R6 good check marker");
        run_to(TS_MOD - 1);
        send_sym(K_IDLE);               // R7: missing marker
        send_sym(K_IDLE);
        check_flags("R7 missing marker");
        run_to(TS_MOD - 1);
        send_sym(K_MARK);
        send_sym(K_IDLE);
        check_flags("R7 sticky after good marker");
        send_sym(K_BAD);                // R8: unknown pattern, ts still advances
        send_sym(K_IDLE);
        check_flags("R8 unknown pattern");
        send_sym(K_MARK);               // R3: header shows the advance
        send_sym(K_RESTART);            // R2
        send_sym(K_IDLE);
        check_flags("R2 restart clears");
        send_sym(K_MARK);               // R2: header (1,0)
        repeat (3) send_sym(K_IDLE);
        check("R6 no pending headers", q.size(), 0);
        check("R4 header count", n_hdr, n_exp_hdr);
        summary();
    end
endmodule